// File: doc/BRIEF.md
# Prioritised Interrupt Index Controller

This block gathers six event pulses from a converter front end into a raw status register, gates them with a software mask, and drives one level interrupt output to the processor. A read-only index register reports the enabled pending source of highest priority as a small code. The code sits one bit up in the word, so the value read is an even offset that an interrupt handler can add to a jump-table base.

Reading the index also acknowledges it. A processor read of the index clears the reported source in the raw status and, with it, the masked status. The index then moves on to the next enabled pending source, or to zero when none remain. A read marked as coming from the debug port returns the same value and leaves all state alone. Software can also drop sources directly by writing ones to a clear register.

The bus is a 16-bit register port with read and write strobes, two byte enables and a debug qualifier. The register read path is combinational. Every state change takes effect at the clock edge that samples the strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the raw status, the mask, the masked status and the index all read zero, and `irq_out` is low.
- R2: A high level on `evt_in[i]` at a clock edge sets raw status bit i. The raw status is read at word address 1, with source i in data bit i.
- R3: The masked status (word address 3) equals raw status AND mask. The mask is read and written at word address 2. `irq_out` is high exactly when some masked status bit is set.
- R4: The index (word address 0) reads as code shifted left by one, and data bit 0 is always zero. Code 0 means nothing is pending. Otherwise the code is i+1 for the lowest-numbered set masked bit i (overflow=1, acquisition done=2, single-shot trigger=3, data ready=4, window-high=5, window-low=6). Codes 7 and 8 never appear.
- R5: A non-debug read of the index with at least one byte enable high (low byte only, high byte only or both) clears the reported source's raw bit at that clock edge. From the next cycle the index shows the next pending source.
- R6: An index read with `bus_dbg` high returns the index and clears no status bit.
- R7: A write to word address 4 with the low byte enabled clears every raw bit whose data bit is 1. Zero bits, and writes with the low byte disabled, change nothing.
- R8: If an event arrives on a source in the same cycle as a clear of that source, by register write or by index read, the bit stays set.
- R9: A read strobe with both byte enables low is not an access and clears nothing.
- R10: Sources masked off are never indexed, and an index read clears only the one reported source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word address of the register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables, bit 0 for the low byte |
| bus_dbg | input | 1 | High when the access comes from the debug port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the current state |
| evt_in | input | 6 | Event pulses, one per source |
| irq_out | output | 1 | Interrupt request, high while any enabled source is pending |

## Verification
Read data is combinational, so the bench samples `bus_rdata` a couple of nanoseconds after it drives a strobe on the falling edge, in the same cycle. Status changes caused by events, clear writes, mask writes and acknowledging reads land on the rising edge that follows. The bench therefore reads the effect back on the next cycle, never in the cycle of the stimulus. `irq_out` and the index are combinational from the status registers, so they are valid one edge after the event or the clear that moves them, and the bench checks them there.

// File: rtl/irq_idx_pkg.sv
`timescale 1ns/1ps
package irq_idx_pkg;

   // Word addresses of the register file
   typedef enum logic [2:0] {
      REG_INDEX  = 3'd0,
      REG_RAW    = 3'd1,
      REG_MASK   = 3'd2,
      REG_MASKED = 3'd3,
      REG_CLEAR  = 3'd4
   } irq_reg_e;

   localparam int unsigned REG_ADDR_BITS = 3;
   localparam int unsigned LANE_BITS     = 8;

   function automatic int unsigned idx_code_width(input int unsigned nsrc);
      return $clog2(nsrc + 1);
   endfunction

endpackage

// File: rtl/irq_bus_decode.sv
`timescale 1ns/1ps
module irq_bus_decode
   import irq_idx_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned BE_W   = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              dbg,
   input  logic [BE_W-1:0]   be,
   output logic              ack_rd,
   output logic              wr_mask,
   output logic              wr_clr
);

   if (ADDR_W < REG_ADDR_BITS) begin : g_bad_addr
      $error("irq_bus_decode: ADDR_W too small for register map");
   end

   logic any_lane;
   logic hit_index, hit_mask, hit_clr;

   assign any_lane  = |be;
   assign hit_index = (addr == ADDR_W'(REG_INDEX));
   assign hit_mask  = (addr == ADDR_W'(REG_MASK));
   assign hit_clr   = (addr == ADDR_W'(REG_CLEAR));

   assign ack_rd  = rd & any_lane & ~dbg & hit_index;
   assign wr_mask = wr & any_lane & hit_mask;
   assign wr_clr  = wr & any_lane & hit_clr;

endmodule

// File: rtl/irq_src_status.sv
`timescale 1ns/1ps
module irq_src_status #(
   parameter int unsigned NUM_SRC = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_vec,
   input  logic [NUM_SRC-1:0] clr_vec,
   output logic [NUM_SRC-1:0] raw
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          raw[i] <= 1'b0;
         else if (set_vec[i]) raw[i] <= 1'b1;
         else if (clr_vec[i]) raw[i] <= 1'b0;
      end
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw & $past(set_vec)) == $past(set_vec))); // R8

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw & $past(clr_vec & ~set_vec)) == '0)); // R7

endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned CODE_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] masked,
   output logic [NUM_SRC-1:0] sel,
   output logic [CODE_W-1:0]  code
);

   if ((1 << CODE_W) < NUM_SRC + 1) begin : g_bad_code
      $error("irq_prio_enc: CODE_W cannot hold NUM_SRC codes");
   end

   // Bit 0 wins; scan from the top so the lowest set bit is kept last.
   always_comb begin
      sel  = '0;
      code = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (masked[i]) begin
            sel    = '0;
            sel[i] = 1'b1;
            code   = CODE_W'(i + 1);
         end
      end
   end

   AST_ONE_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)); // R4

   AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      code <= CODE_W'(NUM_SRC)); // R4

   AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel & ~masked) == '0); // R10

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (masked == '0) |-> (code == '0)); // R4

endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
   import irq_idx_pkg::*;
#(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic                bus_dbg,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_SRC-1:0]  evt_in,
   output logic                irq_out
);

   localparam int unsigned BE_W   = DATA_W / LANE_BITS;
   localparam int unsigned CODE_W = idx_code_width(NUM_SRC);

   if (DATA_W % LANE_BITS != 0) begin : g_bad_width
      $error("irq_vector_ctrl: DATA_W must be whole bytes");
   end
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("irq_vector_ctrl: NUM_SRC out of range");
   end
   if (CODE_W + 1 > DATA_W) begin : g_bad_code
      $error("irq_vector_ctrl: index code does not fit the word");
   end

   logic               ack_rd, wr_mask, wr_clr;
   logic [DATA_W-1:0]  lane_bits;
   logic [NUM_SRC-1:0] mask_q, raw, masked, sel, clr_vec;
   logic [CODE_W-1:0]  code;

   irq_bus_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .dbg(bus_dbg), .be(bus_be),
      .ack_rd(ack_rd), .wr_mask(wr_mask), .wr_clr(wr_clr)
   );

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      assign lane_bits[b*LANE_BITS +: LANE_BITS] = {LANE_BITS{bus_be[b]}};
   end

   // Mask register, written lane by lane
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= (mask_q & ~lane_bits[NUM_SRC-1:0])
                                | (bus_wdata[NUM_SRC-1:0] & lane_bits[NUM_SRC-1:0]);
   end

   // Explicit clears plus the acknowledge of the reported source
   assign clr_vec = (wr_clr ? (bus_wdata[NUM_SRC-1:0] & lane_bits[NUM_SRC-1:0]) : '0)
                  | (ack_rd ? sel : '0);

   irq_src_status #(.NUM_SRC(NUM_SRC)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_vec(evt_in), .clr_vec(clr_vec), .raw(raw)
   );

   assign masked  = raw & mask_q;
   assign irq_out = |masked;

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_enc (
      .clk(clk), .rst_n(rst_n), .masked(masked), .sel(sel), .code(code)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_INDEX))       bus_rdata[CODE_W:1]    = code;
      else if (bus_addr == ADDR_W'(REG_RAW))    bus_rdata[NUM_SRC-1:0] = raw;
      else if (bus_addr == ADDR_W'(REG_MASK))   bus_rdata[NUM_SRC-1:0] = mask_q;
      else if (bus_addr == ADDR_W'(REG_MASKED)) bus_rdata[NUM_SRC-1:0] = masked;
   end

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && (|sel) && !(|(sel & evt_in))) |=> ((raw & $past(sel)) == '0)); // R5

   AST_DEBUG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_dbg && !bus_wr) |=> ((raw & $past(raw)) == $past(raw))); // R6

   AST_IDLE_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_be == '0) && !bus_wr) |=> ((raw & $past(raw)) == $past(raw))); // R9

   AST_INDEX_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(REG_INDEX)) |-> (bus_rdata[0] == 1'b0)); // R4

endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_dbg = 1'b0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [5:0]  evt_in = '0;
   logic        irq_out;
   int          checks = 0;
   int          errors = 0;

   localparam logic [2:0] A_IDX = 3'd0, A_RAW = 3'd1, A_MASK = 3'd2,
                          A_MSKD = 3'd3, A_CLR = 3'd4;

   always #5 clk = ~clk;

   irq_vector_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_be(bus_be), .bus_dbg(bus_dbg),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
      .irq_out(irq_out)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [5:0] v);
      @(negedge clk); evt_in = v;
      @(negedge clk); evt_in = '0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d,
                     input logic [5:0] ev);
      @(negedge clk);
      bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1; evt_in = ev;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0; evt_in = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [1:0] be, input logic dbg,
                     input logic [5:0] ev, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_be = be; bus_dbg = dbg; bus_rd = 1'b1; evt_in = ev;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_be = '0; bus_dbg = 1'b0; evt_in = '0;
   endtask

   // Passive look at a register: no strobe, nothing cleared
   task automatic peek(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #2 d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      peek(A_RAW, d);  check("R1 raw", d, 16'h0);
      peek(A_MASK, d); check("R1 mask", d, 16'h0);
      peek(A_IDX, d);  check("R1 index", d, 16'h0);
      check("R1 irq", {15'b0, irq_out}, 16'h0);
   endtask

   task automatic t_events_masks;
      logic [15:0] d;
      pulse(6'b101000);
      peek(A_RAW, d);  check("R2 raw set", d, 16'h0028);
      peek(A_MSKD, d); check("R3 masked with zero mask", d, 16'h0);
      check("R3 irq low when masked", {15'b0, irq_out}, 16'h0);
      wr(A_MASK, 2'b11, 16'h003F, '0);
      peek(A_MSKD, d); check("R3 masked", d, 16'h0028);
      check("R3 irq high", {15'b0, irq_out}, 16'h1);
      peek(A_IDX, d);  check("R4 index data ready", d, 16'h0008);
   endtask

   task automatic t_ack_reads;
      logic [15:0] d;
      rd(A_IDX, 2'b11, 1'b0, '0, d); check("R5 read value", d, 16'h0008);
      peek(A_RAW, d);  check("R5 reported bit cleared", d, 16'h0020);
      peek(A_IDX, d);  check("R5 next index window-low", d, 16'h000C);
      rd(A_IDX, 2'b01, 1'b0, '0, d); check("R5 low-byte read", d, 16'h000C);
      peek(A_IDX, d);  check("R5 index empty", d, 16'h0);
      check("R5 irq dropped", {15'b0, irq_out}, 16'h0);
   endtask

   task automatic t_debug_and_lanes;
      logic [15:0] d;
      pulse(6'h3F);
      rd(A_IDX, 2'b11, 1'b1, '0, d); check("R6 debug read value", d, 16'h0002);
      peek(A_RAW, d);  check("R6 debug keeps raw", d, 16'h003F);
      rd(A_IDX, 2'b10, 1'b0, '0, d); check("R5 high-byte read", d, 16'h0002);
      peek(A_RAW, d);  check("R5 high-byte clears overflow", d, 16'h003E);
      rd(A_IDX, 2'b00, 1'b0, '0, d);
      peek(A_RAW, d);  check("R9 no-lane read keeps raw", d, 16'h003E);
      peek(A_IDX, d);  check("R4 index acquisition done", d, 16'h0004);
   endtask

   task automatic t_clear_reg;
      logic [15:0] d;
      wr(A_CLR, 2'b01, 16'h0006, '0);
      peek(A_RAW, d);  check("R7 clear bits", d, 16'h0038);
      peek(A_IDX, d);  check("R7 index moves on", d, 16'h0008);
      wr(A_CLR, 2'b01, 16'h0000, '0);
      peek(A_RAW, d);  check("R7 zero write", d, 16'h0038);
      wr(A_CLR, 2'b10, 16'h00FF, '0);
      peek(A_RAW, d);  check("R7 low lane off", d, 16'h0038);
   endtask

   task automatic t_mask_select;
      logic [15:0] d;
      wr(A_MASK, 2'b11, 16'h0010, '0);
      peek(A_IDX, d);  check("R10 only enabled indexed", d, 16'h000A);
      rd(A_IDX, 2'b11, 1'b0, '0, d);
      peek(A_RAW, d);  check("R10 only reported cleared", d, 16'h0028);
      peek(A_IDX, d);  check("R10 masked ones hidden", d, 16'h0);
      check("R3 irq low all masked", {15'b0, irq_out}, 16'h0);
   endtask

   task automatic t_set_wins;
      logic [15:0] d;
      wr(A_MASK, 2'b11, 16'h003F, '0);
      wr(A_CLR, 2'b01, 16'h0008, 6'b001000);
      peek(A_RAW, d);  check("R8 event beats clear write", d, 16'h0028);
      rd(A_IDX, 2'b11, 1'b0, 6'b001000, d); check("R8 read value", d, 16'h0008);
      peek(A_RAW, d);  check("R8 event beats ack", d, 16'h0028);
      rd(A_IDX, 2'b11, 1'b0, '0, d);
      peek(A_RAW, d);  check("R5 ack without event", d, 16'h0020);
      peek(A_IDX, d);  check("R4 index window-low", d, 16'h000C);
   endtask

   initial begin
      #500_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_events_masks();
      t_ack_reads();
      t_debug_and_lanes();
      t_clear_reg();
      t_mask_select();
      t_set_wins();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule